// File: doc/BRIEF.md
# Banked Address Space Decoder

This block sits on the 16-bit address bus of an 8-bit processor. On every access it decides which target answers: system RAM, one of three ROMs, or one of several devices in an I/O window. A small banking register at address 0x0001 sets the layout. Its three low bits pick one of eight layouts, and each layout shows or hides the BASIC ROM (0xA000-0xBFFF), the kernel ROM (0xE000-0xFFFF), the character ROM and the I/O window (both at 0xD000-0xDFFF).

When the I/O window is visible, it is split into a video block, a sound block, colour RAM and two peripheral chips. The video, sound and peripheral register sets repeat through their address slices. For each access the decoder gives a one-hot chip select and a local offset into the selected target. Writes that land on a ROM area pass through to the RAM underneath. The banking register comes out on its own port, so a read of 0x0001 can return it.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the banking register reads 0x37, which is layout 7: 0xA000 selects BASIC ROM, 0xD000 selects video and 0xE000 selects kernel ROM, each at offset 0.
- R2: Layouts 0 and 4 select RAM for every address other than 0x0001, with offset equal to the address.
- R3: Layout 1 shows only character ROM. Layout 2 shows character ROM and kernel ROM. Layout 3 shows character, BASIC and kernel ROM. In all three the I/O window is hidden.
- R4: Layout 5 shows only the I/O window. Layout 6 shows I/O and kernel ROM. Layout 7 shows I/O, BASIC and kernel ROM. In these three, 0xD000-0xDFFF never selects character ROM.
- R5: When character ROM is shown, a read of 0xD000-0xDFFF selects it with offset equal to the address minus 0xD000.
- R6: With I/O visible, 0xD000-0xD3FF selects video at offset address mod 0x40, and 0xD400-0xD7FF selects sound at offset address mod 0x100.
- R7: With I/O visible, 0xD800-0xDBFF selects colour RAM at offset address minus 0xD800. 0xDC00-0xDCFF selects peripheral 1 and 0xDD00-0xDDFF selects peripheral 2, each at offset address mod 0x10. 0xDE00-0xDFFF selects RAM.
- R8: A write to an address that a ROM would answer on a read selects RAM at offset equal to the address. A write into the visible I/O window still selects the I/O device.
- R9: Address 0x0001 always selects the banking register at offset 0. A write there is captured at the next rising clock edge, and all 8 bits can be read back. Only bits 2..0 choose the layout.
- R10: The select vector has bit 0 RAM, 1 BASIC, 2 kernel, 3 character ROM, 4 video, 5 sound, 6 colour RAM, 7 peripheral 1, 8 peripheral 2, 9 banking register. Exactly one bit is set while an access is valid, and no bit is set otherwise.
- R11: BASIC and kernel ROM offsets are the address minus the ROM base (13 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present on the bus this cycle |
| acc_write | input | 1 | The access is a write |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Write data (used for the banking register) |
| sel | output | 10 | One-hot target select |
| offset | output | 16 | Local offset inside the selected target |
| port_rdata | output | 8 | Current banking register value |

## Verification
Select and offset are combinational from the address and the current register, so they are due in the same cycle as the access. The bench drives on the falling edge and samples 2 ns later. A banking write takes effect only after the next rising edge, so each layout change is given a full cycle, and the read-back and the new decoding are checked only at the following falling edge. Every table entry is then probed at the boundary addresses of each region and at mirrored addresses.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int MODE_W  = 3;
  localparam int NUM_TGT = 10;

  localparam int TGT_RAM   = 0;
  localparam int TGT_BASIC = 1;
  localparam int TGT_KERN  = 2;
  localparam int TGT_CHAR  = 3;
  localparam int TGT_VID   = 4;
  localparam int TGT_SND   = 5;
  localparam int TGT_COL   = 6;
  localparam int TGT_PER1  = 7;
  localparam int TGT_PER2  = 8;
  localparam int TGT_PORT  = 9;

  localparam int NUM_IO = 5;
  localparam logic [ADDR_W-1:0] IO_BASE [NUM_IO] =
    '{16'hD000, 16'hD400, 16'hD800, 16'hDC00, 16'hDD00};
  localparam logic [ADDR_W-1:0] IO_SPAN [NUM_IO] =
    '{16'h0400, 16'h0400, 16'h0400, 16'h0100, 16'h0100};
  localparam logic [ADDR_W-1:0] IO_MASK [NUM_IO] =
    '{16'h003F, 16'h00FF, 16'h03FF, 16'h000F, 16'h000F};
  localparam int IO_TGT [NUM_IO] = '{TGT_VID, TGT_SND, TGT_COL, TGT_PER1, TGT_PER2};

  typedef struct packed {
    logic basic;
    logic kern;
    logic chr;
    logic io;
  } vis_t;
endpackage

// File: rtl/mmd_bank_table.sv
module mmd_bank_table
  import mmd_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output vis_t              vis
);
  always_comb begin
    vis = '0;
    case (mode)
      3'd1: vis.chr = 1'b1;
      3'd2: begin vis.chr = 1'b1; vis.kern = 1'b1; end
      3'd3: begin vis.chr = 1'b1; vis.kern = 1'b1; vis.basic = 1'b1; end
      3'd5: vis.io = 1'b1;
      3'd6: begin vis.io = 1'b1; vis.kern = 1'b1; end
      3'd7: begin vis.io = 1'b1; vis.kern = 1'b1; vis.basic = 1'b1; end
      default: vis = '0;
    endcase
  end
endmodule

// File: rtl/mmd_io_subdecode.sv
module mmd_io_subdecode
  import mmd_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic               io_hit,
  output logic [NUM_TGT-1:0] io_sel,
  output logic [ADDR_W-1:0]  io_off
);
  logic [NUM_IO-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IO; gi++) begin : g_win
      assign hit[gi] = (((addr ^ IO_BASE[gi]) & ~(IO_SPAN[gi] - 16'd1)) == '0);
    end
  endgenerate

  always_comb begin
    io_sel = '0;
    io_off = '0;
    for (int i = 0; i < NUM_IO; i++) begin
      if (hit[i]) begin
        io_sel[IO_TGT[i]] = 1'b1;
        io_off = io_off | (addr & IO_MASK[i]);
      end
    end
    io_hit = |hit;
  end
endmodule

// File: rtl/mmd_region_select.sv
module mmd_region_select
  import mmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0001
)(
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  addr,
  input  vis_t               vis,
  input  logic               io_hit,
  input  logic [NUM_TGT-1:0] io_sel,
  input  logic [ADDR_W-1:0]  io_off,
  output logic [NUM_TGT-1:0] sel,
  output logic [ADDR_W-1:0]  offset
);
  localparam int ROM_W = 13;
  localparam int CHR_W = 12;

  logic in_a, in_d, in_e;
  assign in_a = (addr[15:13] == 3'b101);
  assign in_e = (addr[15:13] == 3'b111);
  assign in_d = (addr[15:12] == 4'hD);

  always_comb begin
    sel    = '0;
    offset = addr;
    if (!acc_valid) begin
      offset = '0;
    end else if (addr == PORT_ADDR) begin
      sel[TGT_PORT] = 1'b1;
      offset = '0;
    end else if (in_d && vis.io) begin
      if (io_hit) begin
        sel    = io_sel;
        offset = io_off;
      end else begin
        sel[TGT_RAM] = 1'b1;
      end
    end else if (acc_write) begin
      sel[TGT_RAM] = 1'b1;
    end else if (in_a && vis.basic) begin
      sel[TGT_BASIC] = 1'b1;
      offset = {{(ADDR_W-ROM_W){1'b0}}, addr[ROM_W-1:0]};
    end else if (in_e && vis.kern) begin
      sel[TGT_KERN] = 1'b1;
      offset = {{(ADDR_W-ROM_W){1'b0}}, addr[ROM_W-1:0]};
    end else if (in_d && vis.chr) begin
      sel[TGT_CHAR] = 1'b1;
      offset = {{(ADDR_W-CHR_W){1'b0}}, addr[CHR_W-1:0]};
    end else begin
      sel[TGT_RAM] = 1'b1;
    end
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'h0001,
  parameter logic [DATA_W-1:0] PORT_RESET = 8'h37
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_TGT-1:0] sel,
  output logic [ADDR_W-1:0]  offset,
  output logic [DATA_W-1:0]  port_rdata
);
  logic [DATA_W-1:0]  port_q, port_d;
  logic               port_we;
  vis_t               vis;
  logic               io_hit;
  logic [NUM_TGT-1:0] io_sel;
  logic [ADDR_W-1:0]  io_off;

  assign port_we = acc_valid && acc_write && (addr == PORT_ADDR);

  always_comb begin
    port_d = port_q;
    if (port_we) port_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= PORT_RESET;
    else        port_q <= port_d;
  end

  assign port_rdata = port_q;

  mmd_bank_table i_table (
    .mode (port_q[MODE_W-1:0]),
    .vis  (vis)
  );

  mmd_io_subdecode i_io (
    .addr   (addr),
    .io_hit (io_hit),
    .io_sel (io_sel),
    .io_off (io_off)
  );

  mmd_region_select #(.PORT_ADDR(PORT_ADDR)) i_sel (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .addr      (addr),
    .vis       (vis),
    .io_hit    (io_hit),
    .io_sel    (io_sel),
    .io_off    (io_off),
    .sel       (sel),
    .offset    (offset)
  );
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker
  import mmd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_TGT-1:0] sel,
  input logic [ADDR_W-1:0]  offset,
  input logic [DATA_W-1:0]  port_rdata
);
  logic port_wr;
  assign port_wr = acc_valid && acc_write && (addr == 16'h0001);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones(sel) == 1));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (sel == '0));

  assert_port_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (port_rdata == $past(wdata)));

  assert_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(port_rdata));

  assert_rom_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (addr[15:13] == 3'b101 || addr[15:13] == 3'b111))
      |-> (sel[TGT_RAM] && offset == addr));

  assert_video_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel[TGT_VID] |-> (offset < 16'h0040 && offset == (addr & 16'h003F)));

  assert_periph_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[TGT_PER1] || sel[TGT_PER2]) |-> (offset < 16'h0010));
endmodule

bind mem_map_decoder mmd_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .addr       (addr),
  .wdata      (wdata),
  .sel        (sel),
  .offset     (offset),
  .port_rdata (port_rdata)
);

// File: tb/test_mem_map_decoder.sv
module test_mem_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [9:0]  sel;
  logic [15:0] offset;
  logic [7:0]  port_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int RAM = 0, BAS = 1, KRN = 2, CHR = 3, VID = 4,
                 SND = 5, COL = 6, PR1 = 7, PR2 = 8, PRT = 9;

  always #4 clk = ~clk;

  mem_map_decoder i_mem_map_decoder (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .addr(addr), .wdata(wdata), .sel(sel), .offset(offset), .port_rdata(port_rdata)
  );

  task automatic probe(input logic [15:0] a, input bit w, input int tgt,
                       input logic [15:0] off, input string req);
    logic [9:0] exp_sel;
    exp_sel = 10'(1) << tgt;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; addr = a;
    #2;
    n_chk++;
    if (sel !== exp_sel || offset !== off) begin
      n_bad++;
      $display("FAIL %s addr=%h wr=%0d sel=%b off=%h expected sel=%b off=%h",
               req, a, w, sel, offset, exp_sel, off);
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic set_port(input logic [7:0] v, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; addr = 16'h0001; wdata = v;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    #2;
    n_chk++;
    if (port_rdata !== v) begin
      n_bad++;
      $display("FAIL %s port_rdata=%h expected %h", req, port_rdata, v);
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    n_chk++;
    if (port_rdata !== 8'h37) begin
      n_bad++;
      $display("FAIL R1 port_rdata=%h expected 37", port_rdata);
    end
    probe(16'hA000, 0, BAS, 16'h0000, "R1");
    probe(16'hD000, 0, VID, 16'h0000, "R1");
    probe(16'hE000, 0, KRN, 16'h0000, "R1");
  endtask

  task automatic t_ram_layouts;
    set_port(8'h00, "R9");
    probe(16'hA123, 0, RAM, 16'hA123, "R2");
    probe(16'hD456, 0, RAM, 16'hD456, "R2");
    probe(16'hE789, 0, RAM, 16'hE789, "R2");
    set_port(8'h04, "R9");
    probe(16'hBFFF, 0, RAM, 16'hBFFF, "R2");
    probe(16'hD000, 0, RAM, 16'hD000, "R2");
    probe(16'hFFFF, 0, RAM, 16'hFFFF, "R2");
  endtask

  task automatic t_rom_layouts;
    set_port(8'h01, "R9");
    probe(16'hA000, 0, RAM, 16'hA000, "R3");
    probe(16'hD123, 0, CHR, 16'h0123, "R5");
    probe(16'hE000, 0, RAM, 16'hE000, "R3");
    set_port(8'h02, "R9");
    probe(16'hE010, 0, KRN, 16'h0010, "R11");
    probe(16'hD000, 0, CHR, 16'h0000, "R3");
    probe(16'hA000, 0, RAM, 16'hA000, "R3");
    set_port(8'h03, "R9");
    probe(16'hBFFF, 0, BAS, 16'h1FFF, "R11");
    probe(16'hDFFF, 0, CHR, 16'h0FFF, "R5");
    probe(16'hD100, 1, RAM, 16'hD100, "R8");
  endtask

  task automatic t_io_layouts;
    set_port(8'h05, "R9");
    probe(16'hA000, 0, RAM, 16'hA000, "R4");
    probe(16'hE000, 0, RAM, 16'hE000, "R4");
    probe(16'hD000, 0, VID, 16'h0000, "R4");
    set_port(8'h06, "R9");
    probe(16'hE000, 0, KRN, 16'h0000, "R4");
    probe(16'hA000, 0, RAM, 16'hA000, "R4");
    probe(16'hDE00, 0, RAM, 16'hDE00, "R4");
    set_port(8'hFF, "R9");
    probe(16'hA000, 0, BAS, 16'h0000, "R9");
    probe(16'hFFFF, 0, KRN, 16'h1FFF, "R11");
  endtask

  task automatic t_io_sub;
    set_port(8'h37, "R9");
    probe(16'hD3C1, 0, VID, 16'h0001, "R6");
    probe(16'hD4FF, 0, SND, 16'h00FF, "R6");
    probe(16'hD7A5, 0, SND, 16'h00A5, "R6");
    probe(16'hD800, 0, COL, 16'h0000, "R7");
    probe(16'hDBFF, 0, COL, 16'h03FF, "R7");
    probe(16'hDC1F, 0, PR1, 16'h000F, "R7");
    probe(16'hDCF3, 0, PR1, 16'h0003, "R7");
    probe(16'hDD25, 0, PR2, 16'h0005, "R7");
    probe(16'hDFFF, 0, RAM, 16'hDFFF, "R7");
  endtask

  task automatic t_writes;
    probe(16'hA000, 1, RAM, 16'hA000, "R8");
    probe(16'hE123, 1, RAM, 16'hE123, "R8");
    probe(16'hD020, 1, VID, 16'h0020, "R8");
  endtask

  task automatic t_port_and_idle;
    probe(16'h0001, 0, PRT, 16'h0000, "R9");
    probe(16'h0000, 0, RAM, 16'h0000, "R9");
    @(negedge clk);
    acc_valid = 1'b0; addr = 16'hA000;
    #2;
    n_chk++;
    if (sel !== 10'b0) begin
      n_bad++;
      $display("FAIL R10 idle sel=%b expected 0000000000", sel);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram_layouts();
    t_rom_layouts();
    t_io_layouts();
    t_io_sub();
    t_writes();
    t_port_and_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule